// File: doc/BRIEF.md
# Windowed General-Purpose Register File

This block stores a bank of 16-bit registers. Instructions never name a bank entry directly. They see four registers, R0 to R3, which form a window. A base pointer decides where that window sits in the bank. Each 2-bit selector is added to the pointer, modulo the bank depth, to give the physical entry. A window placed near the top of the bank therefore wraps around to entry 0.

Two combinational read ports, Left and Right, return the registers picked by their selectors. One write port stores a word into the Left-selected register on a rising clock edge. The pointer can be cleared, advanced by an unsigned amount, or held. Moving the window gives each routine a fresh set of R0 to R3 without copying any data. Because a synchronous reset clears only the pointer, the stored data outlives a reset.

Top module: `win_regfile`

## Requirements
- R1: The bank has 64 entries of 16 bits. Each read port returns, combinationally, entry (pointer + selector) mod 64. `sel_left` drives `rd_left` and `sel_right` drives `rd_right`.
- R2: The index wraps. With the pointer at 62, selector 3 reads entry 1 and selector 2 reads entry 0.
- R3: On a rising edge with `wr_en` = 1, `wr_data` is stored in entry (pointer + `sel_left`) mod 64. With `wr_en` = 0, no entry changes.
- R4: A read of the entry being written in the same cycle returns the old contents. The new value is visible only after the edge.
- R5: While `rst` is 1 at a rising edge, the pointer becomes 0. Bank contents are left intact.
- R6: `wp_clr` = 1 sets the pointer to 0 at the next edge. It takes priority over `wp_add`.
- R7: `wp_add` = 1 with `wp_clr` = 0 sets the pointer to (pointer + `wp_step`) mod 64 at the next edge. `wp_step` is unsigned.
- R8: With neither `wp_clr` nor `wp_add` set, the pointer keeps its value.
- R9: A write in the same cycle as a pointer command uses the pointer value from before that edge.
- R10: `wp_out` always shows the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset; clears the pointer only |
| wp_clr | input | 1 | Clear the window pointer |
| wp_add | input | 1 | Advance the window pointer by `wp_step` |
| wp_step | input | 6 | Unsigned pointer increment |
| sel_left | input | 2 | Left selector; picks the read and write register |
| sel_right | input | 2 | Right selector; picks the read register |
| wr_en | input | 1 | Write enable |
| wr_data | input | 16 | Data to store |
| rd_left | output | 16 | Contents of the Left-selected register |
| rd_right | output | 16 | Contents of the Right-selected register |
| wp_out | output | 6 | Current window pointer |

## Verification
A write and a pointer command can fall in the same cycle. The write must then land through the window in force before the edge, not the one the command produces. The bench provokes this overlap in a directed case: it writes with a pointer advance in the same cycle, then moves the window back so the target register can be read out. During bank initialisation, every fourth write also carries a pointer advance. The random phase mixes writes with clear and advance commands. Every read is judged against a bench model that applies the write with the old pointer first and only then moves its own pointer.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  typedef enum logic [1:0] {
    PTR_HOLD  = 2'd0,
    PTR_CLEAR = 2'd1,
    PTR_STEP  = 2'd2
  } ptr_op_e;

  // clear wins over advance
  function automatic ptr_op_e ptr_op_decode(input logic clr, input logic add);
    if (clr)      return PTR_CLEAR;
    else if (add) return PTR_STEP;
    else          return PTR_HOLD;
  endfunction

endpackage

// File: rtl/wrf_pointer.sv
module wrf_pointer
  import wrf_pkg::*;
#(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  ptr_op_e          op,
  input  logic [PTR_W-1:0] step,
  output logic [PTR_W-1:0] wp_q
);

  function automatic logic [PTR_W-1:0] next_base(input logic [PTR_W-1:0] base,
                                                 input logic [PTR_W-1:0] inc);
    return PTR_W'(base + inc);
  endfunction

  logic clear_evt, step_evt, hold_evt;
  assign clear_evt = (op == PTR_CLEAR);
  assign step_evt  = (op == PTR_STEP);
  assign hold_evt  = (op == PTR_HOLD);

  always_ff @(posedge clk) begin
    if (rst)            wp_q <= '0;
    else if (clear_evt) wp_q <= '0;
    else if (step_evt)  wp_q <= next_base(wp_q, step);
  end

  assert_reset_clears_R5: assert property (@(posedge clk) rst |=> wp_q == '0);

  assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
    clear_evt |=> wp_q == '0);

  assert_step_wraps_R7: assert property (@(posedge clk) disable iff (rst)
    step_evt |=> wp_q == PTR_W'($past(wp_q) + $past(step)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    hold_evt |=> $stable(wp_q));

endmodule

// File: rtl/wrf_index.sv
module wrf_index #(
  parameter int PTR_W = 6,
  parameter int SEL_W = 2
) (
  input  logic [PTR_W-1:0] base,
  input  logic [SEL_W-1:0] sel,
  output logic [PTR_W-1:0] idx
);

  function automatic logic [PTR_W-1:0] win_index(input logic [PTR_W-1:0] b,
                                                 input logic [SEL_W-1:0] s);
    return PTR_W'(b + PTR_W'(s));
  endfunction

  assign idx = win_index(base, sel);

endmodule

// File: rtl/wrf_bank.sv
module wrf_bank #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int NUM_RD = 2,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [PTR_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [NUM_RD-1:0][PTR_W-1:0] rd_idx,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_idx[g]];
  end

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int WIN    = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int SEL_W = $clog2(WIN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wp_clr,
  input  logic              wp_add,
  input  logic [PTR_W-1:0]  wp_step,
  input  logic [SEL_W-1:0]  sel_left,
  input  logic [SEL_W-1:0]  sel_right,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_left,
  output logic [DATA_W-1:0] rd_right,
  output logic [PTR_W-1:0]  wp_out
);

  localparam int NUM_RD = 2;

  ptr_op_e                         ptr_op;
  logic [PTR_W-1:0]                base;
  logic [NUM_RD-1:0][SEL_W-1:0]    sels;
  logic [NUM_RD-1:0][PTR_W-1:0]    phys;
  logic [NUM_RD-1:0][DATA_W-1:0]   rdata;

  assign ptr_op = ptr_op_decode(wp_clr, wp_add);
  assign sels   = {sel_right, sel_left};

  wrf_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk  (clk),
    .rst  (rst),
    .op   (ptr_op),
    .step (wp_step),
    .wp_q (base)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_idx
    wrf_index #(.PTR_W(PTR_W), .SEL_W(SEL_W)) u_idx (
      .base (base),
      .sel  (sels[p]),
      .idx  (phys[p])
    );
  end

  // port 0 is Left: it is also the write target, with the pre-edge pointer
  wrf_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NUM_RD(NUM_RD)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (phys[0]),
    .wr_data (wr_data),
    .rd_idx  (phys),
    .rd_data (rdata)
  );

  assign rd_left  = rdata[0];
  assign rd_right = rdata[1];
  assign wp_out   = base;

endmodule

// File: tb/win_regfile_tb.sv
module win_regfile_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wp_clr = 1'b0, wp_add = 1'b0, wr_en = 1'b0;
  logic [5:0]  wp_step = '0;
  logic [1:0]  sel_left = '0, sel_right = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_left, rd_right;
  logic [5:0]  wp_out;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] mdl_mem [64];
  int mdl_wp = 0;
  int last_wr = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  win_regfile u_dut (
    .clk(clk), .rst(rst), .wp_clr(wp_clr), .wp_add(wp_add), .wp_step(wp_step),
    .sel_left(sel_left), .sel_right(sel_right), .wr_en(wr_en), .wr_data(wr_data),
    .rd_left(rd_left), .rd_right(rd_right), .wp_out(wp_out)
  );

  function automatic int phys(input int wp, input int sel);
    return (wp + sel) % 64;
  endfunction

  function automatic string rtag(input int idx, input int sel, input bit wen, input int wil);
    if (wen && idx == wil) return "R4";
    if (idx == last_wr)    return "R3";
    if (mdl_wp + sel >= 64) return "R2";
    return "R1";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit clr, input bit add, input int stp, input bit wen,
                     input int sl, input int sr, input int wd, input string force_tag);
    int il, ir;
    string tl, tr, tp;
    @(negedge clk);
    wp_clr = clr; wp_add = add; wp_step = 6'(stp); wr_en = wen;
    sel_left = 2'(sl); sel_right = 2'(sr); wr_data = 16'(wd);
    #1;
    il = phys(mdl_wp, sl);
    ir = phys(mdl_wp, sr);
    tl = (force_tag != "") ? force_tag : rtag(il, sl, wen, il);
    tr = (force_tag != "") ? force_tag : rtag(ir, sr, wen, il);
    chk(rd_left == mdl_mem[il], tl, rd_left, mdl_mem[il]);
    chk(rd_right == mdl_mem[ir], tr, rd_right, mdl_mem[ir]);
    chk(wp_out == 6'(mdl_wp), "R10", wp_out, mdl_wp);
    @(posedge clk);
    // write resolves with the old pointer first (R9), then the pointer moves
    if (wen) mdl_mem[il] = 16'(wd);
    last_wr = wen ? il : -1;
    if (clr)      begin mdl_wp = 0; tp = "R6"; end
    else if (add) begin mdl_wp = (mdl_wp + stp) % 64; tp = "R7"; end
    else          tp = "R8";
    #1;
    chk(wp_out == 6'(mdl_wp), tp, wp_out, mdl_wp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wp_clr = 0; wp_add = 0; wr_en = 0;
    @(posedge clk); #1;
    mdl_wp = 0; last_wr = -1;
    chk(wp_out == 6'd0, "R5", wp_out, 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (2) @(posedge clk);
    #1;
    chk(wp_out == 6'd0, "R5", wp_out, 0);
    @(negedge clk);
    rst = 1'b0;

    // fill the whole bank; each fourth write also advances by 4 (R9 overlap)
    for (int b = 0; b < 16; b++) begin
      for (int s = 0; s < 4; s++)
        cyc(0, s == 3, 4, 1, s, 0, int'($urandom_range(16'hFFFF)), "R3");
    end

    // wrap at the top of the bank (R2)
    cyc(0, 1, 62, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 3, 2, 0, "R2");
    cyc(0, 0, 0, 1, 3, 3, 16'hBEEF, "R4");
    cyc(0, 0, 0, 0, 3, 1, 0, "R2");

    // write with a simultaneous advance lands in the old window (R9)
    cyc(1, 0, 0, 0, 0, 0, 0, "");
    cyc(0, 1, 10, 0, 0, 0, 0, "");
    cyc(0, 1, 5, 1, 2, 2, 16'hA5A5, "");
    cyc(1, 0, 0, 0, 0, 0, 0, "");
    cyc(0, 1, 11, 0, 0, 0, 0, "");
    cyc(0, 0, 0, 0, 1, 1, 0, "R9");
    chk(rd_left == 16'hA5A5, "R9", rd_left, 16'hA5A5);

    // reset keeps the bank contents (R5)
    cyc(0, 1, 33, 0, 0, 0, 0, "");
    do_reset();
    for (int s = 0; s < 4; s++) cyc(0, 0, 0, 0, s, 3 - s, 0, "R5");

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int c;
      c = int'($urandom_range(7));
      cyc(c == 0, c >= 5, int'($urandom_range(63)), $urandom_range(1) == 1,
          int'($urandom_range(3)), int'($urandom_range(3)),
          int'($urandom_range(16'hFFFF)), "");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule